// File: doc/BRIEF.md
# Relative Branch Resolver

This block takes one instruction word of a 16-bit processor and decides whether it is a PC-relative branch. For such a word it evaluates one of eight conditions on the negative, zero, carry and overflow flags and produces the address of the next instruction. The branch word holds a 3-bit opcode, a 3-bit condition selector and a 10-bit signed displacement counted in words.

The program counter handed in already points at the word after the branch. A taken branch adds twice the sign-extended displacement to that address. A branch that is not taken, or a word that is not a branch, passes the address through unchanged. Every address the block produces is even. The block reads the flags and never produces new ones. By default the three results are registered and reset to zero. A parameter removes that register stage and makes the block purely combinational.

Top module: `jump_unit`

## Requirements
- R1: `is_jump_o` is 1 exactly when instruction bits 15:13 equal binary 001; the condition selector is bits 12:10 and the displacement is bits 9:0.
- R2: Selector 000 takes the branch when Z=0, 001 when Z=1, 010 when C=0 and 011 when C=1.
- R3: Selector 100 takes the branch when N=1 and selector 111 always takes it, whatever the flags.
- R4: Selector 101 takes the branch when N equals V (signed greater-or-equal), and selector 110 takes it when N differs from V (signed less-than).
- R5: A taken branch gives `pc_next_o` = `pc_i` + 2 × sign-extended bits 9:0, so the displacement range is −512 to +511 words. Word 0x2FE4 is a carry-set branch of −0x1C words and 0x3FE3 an unconditional branch of −0x1D words.
- R6: A branch that is not taken gives `pc_next_o` equal to `pc_i`, with `taken_o` at 0.
- R7: A word that is not a branch gives `is_jump_o`=0 and `taken_o`=0, and `pc_next_o` equal to `pc_i`, for any flag values.
- R8: Bit 0 of `pc_next_o` is always 0, even when `pc_i` is odd.
- R9: With the default register stage, the outputs follow the inputs one clock later. While `rst_n` is low, all three outputs are 0.
- R10: Address arithmetic wraps modulo 2^16 in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_i | input | 16 | Instruction word under decode |
| pc_i | input | 16 | Address of the word following the instruction |
| flag_n_i | input | 1 | Negative flag |
| flag_z_i | input | 1 | Zero flag |
| flag_c_i | input | 1 | Carry flag |
| flag_v_i | input | 1 | Overflow flag |
| is_jump_o | output | 1 | Instruction is a relative branch |
| taken_o | output | 1 | Branch condition holds |
| pc_next_o | output | 16 | Address of the next instruction |

## Verification
The signed selectors are driven with all four combinations of N and V. A design that tested N alone, or swapped greater-or-equal with less-than, would take the wrong branch for the overflowed cases. The displacement extremes +511 and −512 words, and wraps across address 0 in both directions, catch a missing sign extension, a missing doubling or a truncated adder. Odd input addresses catch any path that lets bit 0 through. Non-branch words with every flag set catch a design that ignores the opcode field.

// File: rtl/jcu_pkg.sv
package jcu_pkg;

   typedef enum logic [2:0] {
      SEL_ZERO_CLR  = 3'd0,
      SEL_ZERO_SET  = 3'd1,
      SEL_CARRY_CLR = 3'd2,
      SEL_CARRY_SET = 3'd3,
      SEL_NEG       = 3'd4,
      SEL_SGE       = 3'd5,
      SEL_SLT       = 3'd6,
      SEL_ALWAYS    = 3'd7
   } sel_e;

   typedef struct packed {
      logic n;
      logic z;
      logic c;
      logic v;
   } flags_t;

   localparam int SEL_COUNT = 8;

   function automatic logic sel_holds(sel_e s, flags_t f);
      logic r;
      case (s)
         SEL_ZERO_CLR:  r = ~f.z;
         SEL_ZERO_SET:  r = f.z;
         SEL_CARRY_CLR: r = ~f.c;
         SEL_CARRY_SET: r = f.c;
         SEL_NEG:       r = f.n;
         SEL_SGE:       r = ~(f.n ^ f.v);
         SEL_SLT:       r = f.n ^ f.v;
         default:       r = 1'b1;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/jcu_field_split.sv
module jcu_field_split #(
   parameter int INSN_W = 16,
   parameter int OPC_W  = 3,
   parameter int COND_W = 3,
   parameter int OFFS_W = 10,
   parameter logic [OPC_W-1:0] JUMP_OPC = 3'b001
) (
   input  logic [INSN_W-1:0] insn,
   output logic              is_jump,
   output logic [COND_W-1:0] cond,
   output logic [OFFS_W-1:0] offs
);

   localparam int OPC_LSB  = INSN_W - OPC_W;
   localparam int COND_LSB = OFFS_W;

   if (OPC_W + COND_W + OFFS_W != INSN_W) begin : g_bad_split
      $error("jcu_field_split: field widths do not fill the word");
   end

   assign is_jump = (insn[OPC_LSB +: OPC_W] == JUMP_OPC);
   assign cond    = insn[COND_LSB +: COND_W];
   assign offs    = insn[OFFS_W-1:0];

endmodule

// File: rtl/jcu_cond_eval.sv
module jcu_cond_eval #(
   parameter int COND_W = 3
) (
   input  jcu_pkg::flags_t   flags,
   input  logic [COND_W-1:0] cond,
   output logic              hit
);

   localparam int NSEL = 1 << COND_W;

   if (NSEL != jcu_pkg::SEL_COUNT) begin : g_bad_sel
      $error("jcu_cond_eval: selector width must give eight conditions");
   end

   logic [NSEL-1:0] hits;

   for (genvar k = 0; k < NSEL; k++) begin : g_sel
      assign hits[k] = jcu_pkg::sel_holds(jcu_pkg::sel_e'(k), flags);
   end

   assign hit = hits[cond];

endmodule

// File: rtl/jcu_target.sv
module jcu_target #(
   parameter int ADDR_W    = 16,
   parameter int OFFS_W    = 10,
   parameter int WORD_LOG2 = 1
) (
   input  logic [ADDR_W-1:0] pc,
   input  logic [OFFS_W-1:0] offs,
   output logic [ADDR_W-1:0] target,
   output logic [ADDR_W-1:0] seq
);

   localparam int EXT_W = ADDR_W - OFFS_W;
   localparam logic [ADDR_W-1:0] ALIGN_MASK = ~{{(ADDR_W-1){1'b0}}, 1'b1};

   if (EXT_W < WORD_LOG2 || WORD_LOG2 < 1) begin : g_bad_target
      $error("jcu_target: address too narrow for shifted displacement");
   end

   logic [ADDR_W-1:0] offs_ext;
   logic [ADDR_W-1:0] byte_off;
   logic [ADDR_W-1:0] pc_even;
   logic [ADDR_W-1:0] sum;

   assign offs_ext = {{EXT_W{offs[OFFS_W-1]}}, offs};
   assign byte_off = offs_ext << WORD_LOG2;
   assign pc_even  = pc & ALIGN_MASK;
   assign sum      = pc_even + byte_off;
   assign target   = sum & ALIGN_MASK;
   assign seq      = pc_even;

endmodule

// File: rtl/jump_unit.sv
module jump_unit #(
   parameter int ADDR_W    = 16,
   parameter int INSN_W    = 16,
   parameter int OPC_W     = 3,
   parameter int COND_W    = 3,
   parameter int OFFS_W    = 10,
   parameter int WORD_LOG2 = 1,
   parameter logic [OPC_W-1:0] JUMP_OPC = 3'b001,
   parameter bit PIPE_OUT  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [INSN_W-1:0] insn_i,
   input  logic [ADDR_W-1:0] pc_i,
   input  logic              flag_n_i,
   input  logic              flag_z_i,
   input  logic              flag_c_i,
   input  logic              flag_v_i,
   output logic              is_jump_o,
   output logic              taken_o,
   output logic [ADDR_W-1:0] pc_next_o
);

   jcu_pkg::flags_t   flags_c;
   logic              is_jump_c;
   logic [COND_W-1:0] cond_c;
   logic [OFFS_W-1:0] offs_c;
   logic              hit_c;
   logic [ADDR_W-1:0] target_c;
   logic [ADDR_W-1:0] seq_c;
   logic              taken_c;
   logic [ADDR_W-1:0] pc_c;

   assign flags_c = '{n: flag_n_i, z: flag_z_i, c: flag_c_i, v: flag_v_i};

   jcu_field_split #(
      .INSN_W(INSN_W), .OPC_W(OPC_W), .COND_W(COND_W),
      .OFFS_W(OFFS_W), .JUMP_OPC(JUMP_OPC)
   ) i_split (
      .insn(insn_i), .is_jump(is_jump_c), .cond(cond_c), .offs(offs_c)
   );

   jcu_cond_eval #(.COND_W(COND_W)) i_cond (
      .flags(flags_c), .cond(cond_c), .hit(hit_c)
   );

   jcu_target #(
      .ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .WORD_LOG2(WORD_LOG2)
   ) i_target (
      .pc(pc_i), .offs(offs_c), .target(target_c), .seq(seq_c)
   );

   assign taken_c = is_jump_c & hit_c;
   assign pc_c    = taken_c ? target_c : seq_c;

   if (PIPE_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            is_jump_o <= 1'b0;
            taken_o   <= 1'b0;
            pc_next_o <= '0;
         end else begin
            is_jump_o <= is_jump_c;
            taken_o   <= taken_c;
            pc_next_o <= pc_c;
         end
      end
   end else begin : g_comb
      assign is_jump_o = is_jump_c;
      assign taken_o   = taken_c;
      assign pc_next_o = pc_c;
   end

endmodule

// File: rtl/jump_unit_chk.sv
module jump_unit_chk #(
   parameter int ADDR_W    = 16,
   parameter int INSN_W    = 16,
   parameter int OPC_W     = 3,
   parameter int COND_W    = 3,
   parameter int OFFS_W    = 10,
   parameter int WORD_LOG2 = 1,
   parameter logic [OPC_W-1:0] JUMP_OPC = 3'b001,
   parameter bit PIPE_OUT  = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [INSN_W-1:0] insn_i,
   input logic [ADDR_W-1:0] pc_i,
   input logic              flag_n_i,
   input logic              flag_z_i,
   input logic              flag_c_i,
   input logic              flag_v_i,
   input logic              is_jump_o,
   input logic              taken_o,
   input logic [ADDR_W-1:0] pc_next_o
);

   logic [INSN_W-1:0] d_insn;
   logic [ADDR_W-1:0] d_pc;
   logic              d_n, d_z, d_c, d_v;
   logic              valid;

   if (PIPE_OUT) begin : g_dly
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            d_insn <= '0;
            d_pc   <= '0;
            {d_n, d_z, d_c, d_v} <= 4'b0;
            valid  <= 1'b0;
         end else begin
            d_insn <= insn_i;
            d_pc   <= pc_i;
            {d_n, d_z, d_c, d_v} <= {flag_n_i, flag_z_i, flag_c_i, flag_v_i};
            valid  <= 1'b1;
         end
      end
   end else begin : g_now
      assign d_insn = insn_i;
      assign d_pc   = pc_i;
      assign {d_n, d_z, d_c, d_v} = {flag_n_i, flag_z_i, flag_c_i, flag_v_i};
      assign valid  = 1'b1;
   end

   logic [COND_W-1:0] d_sel;
   logic              d_branch;
   logic [ADDR_W-1:0] d_pc_even;
   logic [ADDR_W-1:0] delta;
   logic [ADDR_W-1:0] want_delta;

   assign d_sel      = d_insn[OFFS_W +: COND_W];
   assign d_branch   = d_insn[INSN_W-1 -: OPC_W] == JUMP_OPC;
   assign d_pc_even  = {d_pc[ADDR_W-1:1], 1'b0};
   assign delta      = pc_next_o - d_pc_even;
   assign want_delta = ADDR_W'($signed(d_insn[OFFS_W-1:0])) <<< WORD_LOG2;

   AST_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> is_jump_o == d_branch); // R1
   AST_ZERO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      valid && d_branch && d_sel[2:1] == 2'b00 |-> taken_o == (d_z == d_sel[0])); // R2
   AST_CARRY_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      valid && d_branch && d_sel[2:1] == 2'b01 |-> taken_o == (d_c == d_sel[0])); // R2
   AST_NEG_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      valid && d_branch && d_sel == 3'd4 |-> taken_o == d_n); // R3
   AST_ALWAYS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      valid && d_branch && d_sel == 3'd7 |-> taken_o); // R3
   AST_SIGNED_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      valid && d_branch && d_sel[2:1] == 2'b10 && d_sel[0] |-> taken_o == (d_n == d_v)); // R4
   AST_SIGNED_LT: assert property (@(posedge clk) disable iff (!rst_n)
      valid && d_branch && d_sel == 3'd6 |-> taken_o == (d_n != d_v)); // R4
   AST_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      valid && taken_o |-> delta == want_delta); // R5
   AST_FALLTHROUGH: assert property (@(posedge clk) disable iff (!rst_n)
      valid && !taken_o |-> pc_next_o == d_pc_even); // R6
   AST_NONBRANCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !is_jump_o |-> !taken_o); // R7
   AST_EVEN_PC: assert property (@(posedge clk) disable iff (!rst_n)
      pc_next_o[0] == 1'b0); // R8

endmodule

bind jump_unit jump_unit_chk #(
   .ADDR_W(ADDR_W), .INSN_W(INSN_W), .OPC_W(OPC_W), .COND_W(COND_W),
   .OFFS_W(OFFS_W), .WORD_LOG2(WORD_LOG2), .JUMP_OPC(JUMP_OPC), .PIPE_OUT(PIPE_OUT)
) i_jump_unit_chk (
   .clk(clk), .rst_n(rst_n), .insn_i(insn_i), .pc_i(pc_i),
   .flag_n_i(flag_n_i), .flag_z_i(flag_z_i), .flag_c_i(flag_c_i), .flag_v_i(flag_v_i),
   .is_jump_o(is_jump_o), .taken_o(taken_o), .pc_next_o(pc_next_o)
);

// File: tb/test_jump_unit.sv
`timescale 1ns/1ps
module test_jump_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] insn_i = '0;
   logic [15:0] pc_i = '0;
   logic        flag_n_i = 1'b0, flag_z_i = 1'b0, flag_c_i = 1'b0, flag_v_i = 1'b0;
   logic        is_jump_o, taken_o;
   logic [15:0] pc_next_o;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   jump_unit i_jump_unit (
      .clk(clk), .rst_n(rst_n), .insn_i(insn_i), .pc_i(pc_i),
      .flag_n_i(flag_n_i), .flag_z_i(flag_z_i), .flag_c_i(flag_c_i), .flag_v_i(flag_v_i),
      .is_jump_o(is_jump_o), .taken_o(taken_o), .pc_next_o(pc_next_o)
   );

   // {insn, pc, flags NZCV, expect jump, expect taken, expect next pc}
   localparam int NVEC = 24;
   localparam logic [53:0] VEC [NVEC] = '{
      {16'h2FE4, 16'h1000, 4'b0010, 1'b1, 1'b1, 16'h0FC8}, // R5 carry set, -0x1C words
      {16'h2FE4, 16'h1000, 4'b0000, 1'b1, 1'b0, 16'h1000}, // R2 R6
      {16'h3FE3, 16'h1000, 4'b0000, 1'b1, 1'b1, 16'h0FC6}, // R3 R5 -0x1D words
      {16'h2005, 16'h2000, 4'b0000, 1'b1, 1'b1, 16'h200A}, // R2 zero clear
      {16'h2005, 16'h2000, 4'b0100, 1'b1, 1'b0, 16'h2000}, // R2
      {16'h2405, 16'h2000, 4'b0100, 1'b1, 1'b1, 16'h200A}, // R2 zero set
      {16'h2405, 16'h2000, 4'b0000, 1'b1, 1'b0, 16'h2000}, // R2
      {16'h2810, 16'h0100, 4'b0000, 1'b1, 1'b1, 16'h0120}, // R2 carry clear
      {16'h2810, 16'h0100, 4'b0010, 1'b1, 1'b0, 16'h0100}, // R2
      {16'h31FF, 16'h0100, 4'b1000, 1'b1, 1'b1, 16'h04FE}, // R3 R5 +511 words
      {16'h31FF, 16'h0100, 4'b0000, 1'b1, 1'b0, 16'h0100}, // R3
      {16'h3600, 16'h1000, 4'b1001, 1'b1, 1'b1, 16'h0C00}, // R4 R5 -512 words
      {16'h3600, 16'h1000, 4'b1000, 1'b1, 1'b0, 16'h1000}, // R4
      {16'h3801, 16'h1000, 4'b1000, 1'b1, 1'b1, 16'h1002}, // R4
      {16'h3801, 16'h1000, 4'b0000, 1'b1, 1'b0, 16'h1000}, // R4
      {16'h3801, 16'h1000, 4'b0001, 1'b1, 1'b1, 16'h1002}, // R4
      {16'h3600, 16'h1000, 4'b0000, 1'b1, 1'b1, 16'h0C00}, // R4
      {16'h4504, 16'h1234, 4'b1111, 1'b0, 1'b0, 16'h1234}, // R7
      {16'h1005, 16'h2222, 4'b0000, 1'b0, 1'b0, 16'h2222}, // R7
      {16'h3C01, 16'hFFFE, 4'b1111, 1'b1, 1'b1, 16'h0000}, // R10 upward wrap
      {16'h3FFF, 16'h0000, 4'b0000, 1'b1, 1'b1, 16'hFFFE}, // R10 downward wrap
      {16'h3C00, 16'h1001, 4'b0000, 1'b1, 1'b1, 16'h1000}, // R8 odd pc taken
      {16'h0000, 16'h0001, 4'b0000, 1'b0, 1'b0, 16'h0000}, // R8 R7 odd pc
      {16'h2005, 16'h2001, 4'b0100, 1'b1, 1'b0, 16'h2000}  // R8 R6 odd pc
   };

   task automatic check(string req, logic ej, logic et, logic [15:0] ep);
      checks++;
      if (is_jump_o !== ej || taken_o !== et || pc_next_o !== ep) begin
         errors++;
         $display("FAIL %s: got jump=%b taken=%b pc=%h, expected jump=%b taken=%b pc=%h",
                  req, is_jump_o, taken_o, pc_next_o, ej, et, ep);
      end
   endtask

   task automatic drive(logic [15:0] insn, logic [15:0] pc, logic [3:0] f);
      insn_i = insn;
      pc_i   = pc;
      {flag_n_i, flag_z_i, flag_c_i, flag_v_i} = f;
   endtask

   initial begin
      // R9 reset holds outputs at zero with a branch word present
      drive(16'h3FE3, 16'h1000, 4'b1111);
      repeat (3) @(negedge clk);
      check("R9 reset", 1'b0, 1'b0, 16'h0000);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9 first edge", 1'b1, 1'b1, 16'h0FC6);

      for (int i = 0; i < NVEC; i++) begin
         @(negedge clk);
         drive(VEC[i][53:38], VEC[i][37:22], VEC[i][21:18]);
         @(negedge clk);
         check($sformatf("vector %0d", i), VEC[i][17], VEC[i][16], VEC[i][15:0]);
      end

      // R9 one-clock latency: new inputs not visible before the edge
      @(negedge clk);
      drive(16'h3FE3, 16'h1000, 4'b0000);
      @(negedge clk);
      drive(16'h4504, 16'h5554, 4'b0000);
      #2;
      check("R9 hold before edge", 1'b1, 1'b1, 16'h0FC6);
      @(negedge clk);
      check("R9 after edge", 1'b0, 1'b0, 16'h5554);

      // R7 flags have no effect on a non-branch word
      for (int f = 0; f < 16; f++) begin
         drive(16'hC3FF, 16'h0ABC, 4'(f));
         @(negedge clk);
         check("R7 flag sweep", 1'b0, 1'b0, 16'h0ABC);
      end

      // R3 unconditional under every flag pattern
      for (int f = 0; f < 16; f++) begin
         drive(16'h3C02, 16'h0400, 4'(f));
         @(negedge clk);
         check("R3 always sweep", 1'b1, 1'b1, 16'h0404);
      end

      // R9 asynchronous reset mid-run
      drive(16'h3FE3, 16'h1000, 4'b0000);
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check("R9 async reset", 1'b0, 1'b0, 16'h0000);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R9 reset release", 1'b1, 1'b1, 16'h0FC6);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: got hang, expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule